// File: doc/BRIEF.md
# Dual Programmable Blink Generator with Output Select

This block drives eight LED pins from two independent blink waveforms. Each waveform is set by two 8-bit values. A period value `P` makes one blink cycle last `256*(P+1)` ticks. A duty value `D` makes the LED lit for `256-D` of the 256 phase steps in each cycle.

A tick divider turns the system clock into a tick every `CLK_DIV` clocks. The nominal tick rate is 256×38 Hz, so one cycle lasts `(P+1)/38` seconds. That gives a range from about 26 ms to about 6.7 s.

Every pin has a 2-bit source field that selects one of four sources: forced lit, released, waveform 0 or waveform 1. The outputs are drive-low enables for open-drain pads. A 1 pulls the pin low and the LED turns on. A 0 releases the pin, and an external pull-up holds it high.

Each waveform generator contains a small state machine with two states:
- `GEN_DARK`: the LED is off. It moves to `GEN_LIT` when the phase is at or above the duty value.
- `GEN_LIT`: the LED is on. It moves back to `GEN_DARK` when the phase falls below the duty value, which happens at the phase wrap.

Reset puts both machines in `GEN_DARK`.

Top module: `blink_router`

## Requirements
- R1: The phase counter of a generator advances by exactly one step every `P+1` ticks, so one blink cycle lasts `256*(P+1)` ticks (clock cycles when `CLK_DIV` = 1).
- R2: A generator is lit, and a pin following it is driven low, during exactly `(256-D)*(P+1)` ticks of each cycle. Lit means the phase is at or above `D`.
- R3: A duty value of 00h keeps the generator lit for the whole cycle.
- R4: Source code 2'b00 drives the pin low (`drive_low` = 1) on every cycle.
- R5: Source code 2'b01 releases the pin (`drive_low` = 0) on every cycle.
- R6: Source code 2'b10 makes the pin follow generator 0, and 2'b11 makes it follow generator 1.
- R7: Pin k, for k = 0..3, takes its source from `src_sel_lo[2k+1:2k]`. Pin k+4 takes its source from `src_sel_hi[2k+1:2k]`.
- R8: A new period value takes effect only at the next phase wrap. The cycle in progress completes with its old length.
- R9: While reset is asserted, both generators are dark, so pins following a waveform are released.
- R10: The two generators run independently. Gen0 set to P=37, D=128 gives a 50 % cycle of 9728 ticks. Gen1 set to P=9, D=192 gives a 25 % cycle of 2560 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen0_period | input | 8 | Period value P of generator 0 |
| gen0_duty | input | 8 | Duty value D of generator 0 |
| gen1_period | input | 8 | Period value P of generator 1 |
| gen1_duty | input | 8 | Duty value D of generator 1 |
| src_sel_lo | input | 8 | Source fields for pins 0 to 3, two bits each |
| src_sel_hi | input | 8 | Source fields for pins 4 to 7, two bits each |
| drive_low | output | 8 | Per-pin pull-low enable (1 = LED on) |

## Verification
The assertions check on every cycle that:
- the phase moves by at most one step per cycle;
- a zero duty value forces the lit state;
- the forced-lit and released codes hold their pins;
- the latched period changes only at the start of a cycle;
- both generators are dark during reset.

Only the bench scenarios can show the cycle lengths and lit-tick totals for the various period and duty pairs. The same holds for the field-to-pin mapping and for the deferred period change measured from one wrap to the next.

// File: rtl/blink_pkg.sv
package blink_pkg;
    typedef enum logic [1:0] {
        SRC_ON   = 2'b00,
        SRC_OFF  = 2'b01,
        SRC_GEN0 = 2'b10,
        SRC_GEN1 = 2'b11
    } src_sel_e;

    typedef enum logic {
        GEN_DARK = 1'b0,
        GEN_LIT  = 1'b1
    } gen_state_e;

    localparam int NUM_GEN = 2;
    localparam int SEL_W   = 2;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int CLK_DIV = 5140
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    generate
        if (CLK_DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(CLK_DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick = (cnt_q == CW'(CLK_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/blink_gen.sv
module blink_gen
    import blink_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             lit,
    output logic [CNT_W-1:0] phase_o,
    output logic [CNT_W-1:0] pre_o,
    output logic [CNT_W-1:0] psc_o
);
    logic [CNT_W-1:0] phase_q, pre_q, psc_q, psc_eff;
    logic             at_start;
    gen_state_e       st_q, st_d;

    // A cycle begins when both counters are zero; only then is a new period accepted.
    assign at_start = (phase_q == '0) && (pre_q == '0);
    assign psc_eff  = at_start ? period_in : psc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            pre_q   <= '0;
            psc_q   <= '1;
        end else begin
            psc_q <= psc_eff;
            if (tick) begin
                if (pre_q == psc_eff) begin
                    pre_q   <= '0;
                    phase_q <= phase_q + 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GEN_DARK;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GEN_DARK: if (phase_q >= duty_in) st_d = GEN_LIT;
            GEN_LIT:  if (phase_q <  duty_in) st_d = GEN_DARK;
            default:  st_d = GEN_DARK;
        endcase
    end

    // Outputs
    always_comb begin
        lit     = (st_q == GEN_LIT);
        phase_o = phase_q;
        pre_o   = pre_q;
        psc_o   = psc_q;
    end
endmodule

// File: rtl/pin_router.sv
module pin_router
    import blink_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input  logic [SEL_W*NUM_OUT-1:0] sel_vec,
    input  logic [NUM_GEN-1:0]       lit_vec,
    output logic [NUM_OUT-1:0]       drive_low
);
    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
            src_sel_e src;
            always_comb begin
                src = src_sel_e'(sel_vec[SEL_W*i +: SEL_W]);
                unique case (src)
                    SRC_ON:   drive_low[i] = 1'b1;
                    SRC_OFF:  drive_low[i] = 1'b0;
                    SRC_GEN0: drive_low[i] = lit_vec[0];
                    SRC_GEN1: drive_low[i] = lit_vec[1];
                    default:  drive_low[i] = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/blink_router.sv
module blink_router
    import blink_pkg::*;
#(
    parameter int CLK_DIV = 5140,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gen0_period,
    input  logic [CNT_W-1:0] gen0_duty,
    input  logic [CNT_W-1:0] gen1_period,
    input  logic [CNT_W-1:0] gen1_duty,
    input  logic [7:0]       src_sel_lo,
    input  logic [7:0]       src_sel_hi,
    output logic [7:0]       drive_low
);
    localparam int NUM_OUT = 8;

    logic                tick;
    logic [CNT_W-1:0]    period_w [NUM_GEN];
    logic [CNT_W-1:0]    duty_w   [NUM_GEN];
    logic [CNT_W-1:0]    phase_w  [NUM_GEN];
    logic [CNT_W-1:0]    pre_w    [NUM_GEN];
    logic [CNT_W-1:0]    psc_w    [NUM_GEN];
    logic [NUM_GEN-1:0]  lit_w;

    assign period_w[0] = gen0_period;
    assign period_w[1] = gen1_period;
    assign duty_w[0]   = gen0_duty;
    assign duty_w[1]   = gen1_duty;

    tick_divider #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
            blink_gen #(.CNT_W(CNT_W)) u_gen (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .period_in(period_w[g]),
                .duty_in  (duty_w[g]),
                .lit      (lit_w[g]),
                .phase_o  (phase_w[g]),
                .pre_o    (pre_w[g]),
                .psc_o    (psc_w[g])
            );
        end
    endgenerate

    pin_router #(.NUM_OUT(NUM_OUT)) u_route (
        .sel_vec  ({src_sel_hi, src_sel_lo}),
        .lit_vec  (lit_w),
        .drive_low(drive_low)
    );
endmodule

// File: rtl/blink_router_chk.sv
module blink_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel_f0,
    input logic [1:0] sel_f7,
    input logic       drv0,
    input logic       drv7,
    input logic [7:0] duty0,
    input logic [7:0] phase0,
    input logic [7:0] pre0,
    input logic [7:0] psc0,
    input logic       lit0,
    input logic       lit1
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (phase0 == $past(phase0) || phase0 == 8'($past(phase0) + 8'd1)));

    assert_zero_duty_lit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(duty0) == 8'd0) |-> lit0);

    assert_code_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_f0 == 2'b00) |-> drv0);

    assert_code_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_f7 == 2'b01) |-> !drv7);

    assert_period_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase0 != 8'd0 || pre0 != 8'd0) |=> $stable(psc0));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_dark_R9: assert (!lit0 && !lit1);
        end
    end
endmodule

bind blink_router blink_router_chk chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_f0(src_sel_lo[1:0]),
    .sel_f7(src_sel_hi[7:6]),
    .drv0  (drive_low[0]),
    .drv7  (drive_low[7]),
    .duty0 (gen0_duty),
    .phase0(phase_w[0]),
    .pre0  (pre_w[0]),
    .psc0  (psc_w[0]),
    .lit0  (lit_w[0]),
    .lit1  (lit_w[1])
);

// File: tb/tb_blink_router.sv
module tb_blink_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] p0 = 8'd0, d0 = 8'd0, p1 = 8'd0, d1 = 8'd0;
    logic [7:0] sel_lo = 8'h55, sel_hi = 8'h72;
    logic [7:0] drive_low;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    blink_router #(.CLK_DIV(1)) dut (
        .clk(clk), .rst_n(rst_n),
        .gen0_period(p0), .gen0_duty(d0),
        .gen1_period(p1), .gen1_duty(d1),
        .src_sel_lo(sel_lo), .src_sel_hi(sel_hi),
        .drive_low(drive_low)
    );

    // {period, duty, expected lit ticks over one cycle}
    localparam logic [31:0] VEC [6] = '{
        {8'd0, 8'd0,   16'd256},
        {8'd0, 8'd128, 16'd128},
        {8'd0, 8'd255, 16'd1},
        {8'd1, 8'd64,  16'd384},
        {8'd3, 8'd192, 16'd256},
        {8'd9, 8'd192, 16'd640}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_fall(input int pin);
        logic prev;
        prev = drive_low[pin];
        forever begin
            @(negedge clk);
            if (prev && !drive_low[pin]) break;
            prev = drive_low[pin];
        end
    endtask

    // Cycles from one falling edge to the next, optionally changing gen0 period mid-way
    task automatic fall_gap(input int pin, input int chg_at, input logic [7:0] new_p, output int gap);
        logic prev;
        prev = drive_low[pin];
        gap = 0;
        forever begin
            @(negedge clk);
            gap++;
            if (gap == chg_at) p0 = new_p;
            if (prev && !drive_low[pin]) break;
            prev = drive_low[pin];
        end
    endtask

    initial begin
        int old_p;
        int c4, c6, on5, off7, gap;
        // R9: reset state
        cycles(3);
        check(drive_low == 8'b0010_0000, "R9 reset outputs", drive_low, 8'b0010_0000);
        @(negedge clk) rst_n = 1'b1;
        cycles(2);
        check(drive_low[3:0] == 4'h0, "R5 released pins 0-3", drive_low[3:0], 0);

        // Table: both generators with the same settings
        old_p = 255;
        for (int v = 0; v < 6; v++) begin
            p0 = VEC[v][31:24]; d0 = VEC[v][23:16];
            p1 = VEC[v][31:24]; d1 = VEC[v][23:16];
            cycles(256 * (old_p + 1) + 256 * (int'(p0) + 1) + 4);
            c4 = 0; c6 = 0; on5 = 0; off7 = 0;
            for (int k = 0; k < 256 * (int'(p0) + 1); k++) begin
                @(negedge clk);
                c4 += drive_low[4]; c6 += drive_low[6];
                on5 += drive_low[5]; off7 += drive_low[7];
            end
            check(c4 == int'(VEC[v][15:0]), "R2/R3 gen0 lit ticks", c4, VEC[v][15:0]);
            check(c6 == int'(VEC[v][15:0]), "R6 gen1 pin lit ticks", c6, VEC[v][15:0]);
            check(on5 == 256 * (int'(p0) + 1), "R4 forced-on pin", on5, 256 * (int'(p0) + 1));
            check(off7 == 0, "R5 released pin", off7, 0);
            old_p = int'(p0);
        end

        // R7: field-to-pin mapping
        for (int k = 0; k < 8; k++) begin
            logic [15:0] f;
            f = 16'h5555;
            f[2*k +: 2] = 2'b00;
            sel_lo = f[7:0]; sel_hi = f[15:8];
            cycles(1);
            check(drive_low == 8'(1 << k), "R7 field mapping", drive_low, 1 << k);
        end

        // R10: worked example
        p0 = 8'd37; d0 = 8'd128; p1 = 8'd9; d1 = 8'd192;
        sel_lo = 8'h00; sel_hi = 8'hFA;
        cycles(2560 + 9728 + 4);
        c4 = 0; on5 = 0;
        for (int k = 0; k < 9728; k++) begin
            @(negedge clk);
            c4 += drive_low[4]; on5 += drive_low[5];
            if (drive_low[3:0] != 4'hF) on5 = -100000;
        end
        check(c4 == 4864, "R10 gen0 pin4 50%", c4, 4864);
        check(on5 == 4864, "R10 pin5 on gen0 and pins 0-3 on", on5, 4864);
        c6 = 0;
        for (int k = 0; k < 2560; k++) begin
            @(negedge clk);
            c6 += drive_low[6];
        end
        check(c6 == 640, "R10 gen1 pin6 25%", c6, 640);

        // R1/R8: cycle length and deferred period change
        p0 = 8'd1; d0 = 8'd128;
        cycles(9728 + 512 + 4);
        wait_fall(4);
        fall_gap(4, 0, 8'd1, gap);
        check(gap == 512, "R1 cycle length P=1", gap, 512);
        fall_gap(4, 100, 8'd3, gap);
        check(gap == 512, "R8 old period completes", gap, 512);
        fall_gap(4, 0, 8'd3, gap);
        check(gap == 1024, "R8 new period applied", gap, 1024);

        // R9: reset mid-blink releases followed pins
        d0 = 8'd0;
        cycles(4);
        check(drive_low[4] == 1'b1, "R3 zero duty lit", drive_low[4], 1);
        rst_n = 1'b0;
        cycles(2);
        check(drive_low[4] == 1'b0 && drive_low[6] == 1'b0, "R9 reset mid-run", drive_low, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule